// File: doc/BRIEF.md
# Replay-Aware Wakeup Time Predictor

This block predicts, for each static instruction, how many cycles the instruction will wait before its operands are ready. A scheduler that wakes instructions from a countdown instead of from operand broadcasts uses the prediction. A lookup is issued with the instruction address in parallel with fetch. One cycle later the block returns the integer part of a stored estimate when the address hits. When it misses, the block returns a global default.

When an instruction finally executes, the block receives three things on its update port: the observed wakeup time, the number of times the instruction was replayed, and the current replay cost r, which is a signed power of two. The matching entry then moves one sixteenth of the way toward a target sample. The target is the observed time plus r times the replay count. The estimate is therefore pushed upward after costly replays and drifts back down while none occur. An update that misses the table allocates a way in its set. The same update also trains the default register with the same rule.

Top module: `wakeup_pred`

## Requirements
- R1: `pred_valid_o` is high exactly in the cycle after a cycle with `lkp_valid_i` high. Whenever `pred_valid_o` is low, `pred_hit_o` and `pred_o` are zero.
- R2: After reset no entry is valid. A lookup misses and returns the default, whose reset estimate is DEF_INIT + 0.5 cycles, so `pred_o` equals DEF_INIT.
- R3: An update that misses allocates an entry with the estimate (wakeup + 0.5) in fixed point with 4 fraction bits. A later lookup of that address hits and returns the wakeup value.
- R4: An update that hits replaces the estimate E (in 1/16 cycle units) with E + ((S − E) >>> 4), where >>> is an arithmetic shift that rounds toward minus infinity and S = 16·wakeup + 8 ± P. `pred_o` is E[11:4].
- R5: P = replays · 2^(r_log − 2) cycles, expressed in 1/16 units as replays << (r_log + 2). `r_neg_i` = 0 adds P and `r_neg_i` = 1 subtracts it.
- R6: The estimate saturates at 0 and at 4095/16. A predicted value therefore stays in the range 0 to 255 under any run of updates.
- R7: Every update that misses the table also steps the default estimate with the R4 rule. The default is what later misses return.
- R8: A lookup and an update in the same cycle to the same address return a result that already includes that update, so it hits.
- R9: The set index is the address modulo SETS and the tag is the rest of the address. Allocations in a set take ways round-robin from way 0. With WAYS+1 distinct tags in one set, the first tag is evicted.
- R10: Repeated lookups of one address with no update between them return identical results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lkp_valid_i | input | 1 | Lookup request |
| lkp_pc_i | input | ADDR_W | Lookup instruction address |
| upd_valid_i | input | 1 | Update request |
| upd_pc_i | input | ADDR_W | Update instruction address |
| upd_wakeup_i | input | INT_W | Observed wakeup time in cycles |
| upd_replays_i | input | CNT_W | Replays experienced by the instruction |
| r_neg_i | input | 1 | Replay cost sign (1 = negative) |
| r_log_i | input | RLOG_W | Replay cost magnitude, 2^(r_log − 2) cycles |
| pred_valid_o | output | 1 | Prediction valid |
| pred_hit_o | output | 1 | Prediction came from the table |
| pred_o | output | INT_W | Predicted wakeup cycles |

## Verification
The bench builds the predictor with 8 sets, 4 ways and 16-bit addresses. Random addresses drawn from a pool of 64 then map eight tags onto each set. This keeps round-robin evictions, misses that train the default and same-cycle update/lookup collisions frequent. It also keeps enough hits that entries converge and saturate. The estimate width stays at its default, so the 0 and 255 clamps are reached with long penalty runs at the largest replay cost.

// File: rtl/wkp_pkg.sv
package wkp_pkg;
  localparam int unsigned FRAC_W    = 4;  // estimate fraction bits
  localparam int unsigned MU_SHIFT  = 4;  // averaging rate 1/16
  localparam int unsigned R_BIAS    = 2;  // r_log 0 encodes r = 1/4
  localparam int unsigned HALF      = 1 << (FRAC_W - 1);

  typedef enum logic {
    R_POS = 1'b0,
    R_NEG = 1'b1
  } r_sign_e;
endpackage

// File: rtl/wkp_step.sv
module wkp_step #(
  parameter int unsigned INT_W  = 8,
  parameter int unsigned CNT_W  = 4,
  parameter int unsigned RLOG_W = 3
) (
  input  logic [INT_W+wkp_pkg::FRAC_W-1:0] est_i,
  input  logic [INT_W-1:0]                 obs_i,
  input  logic [CNT_W-1:0]                 rep_i,
  input  logic                             r_neg_i,
  input  logic [RLOG_W-1:0]                r_log_i,
  output logic [INT_W+wkp_pkg::FRAC_W-1:0] est_o
);
  import wkp_pkg::*;

  localparam int unsigned EST_W   = INT_W + FRAC_W;
  localparam int unsigned RSH     = FRAC_W - R_BIAS;
  localparam int unsigned ACC_W   = EST_W + CNT_W + (1 << RLOG_W) + 2;
  localparam int unsigned EST_MAX = (1 << EST_W) - 1;

  logic        [ACC_W-1:0] pen_u;
  logic signed [ACC_W-1:0] sample, delta, nxt;

  always_comb begin
    pen_u  = ACC_W'(rep_i) << (r_log_i + RSH);
    sample = $signed(ACC_W'(obs_i) << FRAC_W) + $signed(ACC_W'(HALF));
    if (r_sign_e'(r_neg_i) == R_NEG) sample = sample - $signed(pen_u);
    else                             sample = sample + $signed(pen_u);
    delta = sample - $signed(ACC_W'(est_i));
    nxt   = $signed(ACC_W'(est_i)) + (delta >>> MU_SHIFT);
    if (nxt < 0)                                est_o = '0;
    else if (nxt > $signed(ACC_W'(EST_MAX)))    est_o = EST_W'(EST_MAX);
    else                                        est_o = nxt[EST_W-1:0];
  end
endmodule

// File: rtl/wkp_default.sv
module wkp_default #(
  parameter int unsigned INT_W    = 8,
  parameter int unsigned CNT_W    = 4,
  parameter int unsigned RLOG_W   = 3,
  parameter int unsigned DEF_INIT = 2
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             en_i,
  input  logic [INT_W-1:0]                 obs_i,
  input  logic [CNT_W-1:0]                 rep_i,
  input  logic                             r_neg_i,
  input  logic [RLOG_W-1:0]                r_log_i,
  output logic [INT_W+wkp_pkg::FRAC_W-1:0] est_o
);
  import wkp_pkg::*;

  localparam int unsigned EST_W  = INT_W + FRAC_W;
  localparam int unsigned RST_EST = (DEF_INIT << FRAC_W) + HALF;

  logic [EST_W-1:0] def_q, def_d;

  wkp_step #(.INT_W(INT_W), .CNT_W(CNT_W), .RLOG_W(RLOG_W)) u_step (
    .est_i  (def_q),
    .obs_i  (obs_i),
    .rep_i  (rep_i),
    .r_neg_i(r_neg_i),
    .r_log_i(r_log_i),
    .est_o  (def_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   def_q <= EST_W'(RST_EST);
    else if (en_i) def_q <= def_d;
  end

  assign est_o = def_q;
endmodule

// File: rtl/wkp_table.sv
module wkp_table #(
  parameter int unsigned SETS  = 128,
  parameter int unsigned WAYS  = 4,
  parameter int unsigned TAG_W = 25,
  parameter int unsigned EST_W = 12
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  // lookup read port
  input  logic [$clog2(SETS)-1:0] rd_idx_i,
  input  logic [TAG_W-1:0]        rd_tag_i,
  output logic                    rd_hit_o,
  output logic [EST_W-1:0]        rd_est_o,
  // update read-modify-write port
  input  logic [$clog2(SETS)-1:0] up_idx_i,
  input  logic [TAG_W-1:0]        up_tag_i,
  output logic                    up_hit_o,
  output logic [EST_W-1:0]        up_est_o,
  input  logic                    we_i,
  input  logic [EST_W-1:0]        wr_est_i
);
  localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  logic [WAYS-1:0]  valid_q [SETS];
  logic [TAG_W-1:0] tag_q   [SETS][WAYS];
  logic [EST_W-1:0] est_q   [SETS][WAYS];
  logic [WAY_W-1:0] rr_q    [SETS];

  logic [WAYS-1:0]  rd_match, up_match;
  logic [WAY_W-1:0] up_way, vic_way, vic_nxt;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign rd_match[w] = valid_q[rd_idx_i][w] && (tag_q[rd_idx_i][w] == rd_tag_i);
    assign up_match[w] = valid_q[up_idx_i][w] && (tag_q[up_idx_i][w] == up_tag_i);
  end

  always_comb begin
    rd_est_o = '0;
    up_est_o = '0;
    up_way   = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (rd_match[w]) rd_est_o = est_q[rd_idx_i][w];
      if (up_match[w]) begin
        up_est_o = est_q[up_idx_i][w];
        up_way   = WAY_W'(w);
      end
    end
  end

  assign rd_hit_o = |rd_match;
  assign up_hit_o = |up_match;
  assign vic_way  = rr_q[up_idx_i];
  assign vic_nxt  = (vic_way == WAY_W'(WAYS - 1)) ? '0 : vic_way + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        rr_q[s]    <= '0;
      end
    end else if (we_i && !up_hit_o) begin
      valid_q[up_idx_i][vic_way] <= 1'b1;
      rr_q[up_idx_i]             <= vic_nxt;
    end
  end

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      if (up_hit_o) begin
        est_q[up_idx_i][up_way] <= wr_est_i;
      end else begin
        tag_q[up_idx_i][vic_way] <= up_tag_i;
        est_q[up_idx_i][vic_way] <= wr_est_i;
      end
    end
  end
endmodule

// File: rtl/wakeup_pred.sv
module wakeup_pred #(
  parameter int unsigned SETS     = 128,
  parameter int unsigned WAYS     = 4,
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned INT_W    = 8,
  parameter int unsigned CNT_W    = 4,
  parameter int unsigned RLOG_W   = 3,
  parameter int unsigned DEF_INIT = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lkp_valid_i,
  input  logic [ADDR_W-1:0] lkp_pc_i,
  input  logic              upd_valid_i,
  input  logic [ADDR_W-1:0] upd_pc_i,
  input  logic [INT_W-1:0]  upd_wakeup_i,
  input  logic [CNT_W-1:0]  upd_replays_i,
  input  logic              r_neg_i,
  input  logic [RLOG_W-1:0] r_log_i,
  output logic              pred_valid_o,
  output logic              pred_hit_o,
  output logic [INT_W-1:0]  pred_o
);
  import wkp_pkg::*;

  localparam int unsigned IDX_W = $clog2(SETS);
  localparam int unsigned TAG_W = ADDR_W - IDX_W;
  localparam int unsigned EST_W = INT_W + FRAC_W;

  logic              lkp_v_q;
  logic [ADDR_W-1:0] lkp_pc_q;
  logic              rd_hit, up_hit;
  logic [EST_W-1:0]  rd_est, up_est, step_est, wr_est, def_est, init_est;

  // lookup address is registered; the table is read after the same edge's write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lkp_v_q  <= 1'b0;
      lkp_pc_q <= '0;
    end else begin
      lkp_v_q  <= lkp_valid_i;
      if (lkp_valid_i) lkp_pc_q <= lkp_pc_i;
    end
  end

  wkp_table #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .EST_W(EST_W)) u_table (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_idx_i(lkp_pc_q[IDX_W-1:0]),
    .rd_tag_i(lkp_pc_q[ADDR_W-1:IDX_W]),
    .rd_hit_o(rd_hit),
    .rd_est_o(rd_est),
    .up_idx_i(upd_pc_i[IDX_W-1:0]),
    .up_tag_i(upd_pc_i[ADDR_W-1:IDX_W]),
    .up_hit_o(up_hit),
    .up_est_o(up_est),
    .we_i    (upd_valid_i),
    .wr_est_i(wr_est)
  );

  wkp_step #(.INT_W(INT_W), .CNT_W(CNT_W), .RLOG_W(RLOG_W)) u_step (
    .est_i  (up_est),
    .obs_i  (upd_wakeup_i),
    .rep_i  (upd_replays_i),
    .r_neg_i(r_neg_i),
    .r_log_i(r_log_i),
    .est_o  (step_est)
  );

  wkp_default #(
    .INT_W(INT_W), .CNT_W(CNT_W), .RLOG_W(RLOG_W), .DEF_INIT(DEF_INIT)
  ) u_default (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (upd_valid_i && !up_hit),
    .obs_i  (upd_wakeup_i),
    .rep_i  (upd_replays_i),
    .r_neg_i(r_neg_i),
    .r_log_i(r_log_i),
    .est_o  (def_est)
  );

  assign init_est = {upd_wakeup_i, FRAC_W'(HALF)};
  assign wr_est   = up_hit ? step_est : init_est;

  always_comb begin
    pred_valid_o = lkp_v_q;
    pred_hit_o   = 1'b0;
    pred_o       = '0;
    if (lkp_v_q) begin
      pred_hit_o = rd_hit;
      pred_o     = rd_hit ? rd_est[EST_W-1:FRAC_W] : def_est[EST_W-1:FRAC_W];
    end
  end
endmodule

// File: rtl/wakeup_pred_chk.sv
module wakeup_pred_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned INT_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              lkp_valid_i,
  input logic [ADDR_W-1:0] lkp_pc_i,
  input logic              upd_valid_i,
  input logic [ADDR_W-1:0] upd_pc_i,
  input logic              pred_valid_o,
  input logic              pred_hit_o,
  input logic [INT_W-1:0]  pred_o
);
  assert_valid_follows_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkp_valid_i |=> pred_valid_o);

  assert_valid_drops_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lkp_valid_i |=> !pred_valid_o);

  assert_idle_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pred_valid_o |-> (pred_o == '0 && !pred_hit_o));

  assert_update_first_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lkp_valid_i && upd_valid_i && lkp_pc_i == upd_pc_i) |=> pred_hit_o);

  assert_repeat_stable_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lkp_valid_i && $past(lkp_valid_i) && lkp_pc_i == $past(lkp_pc_i) && !upd_valid_i)
    |=> (pred_o == $past(pred_o) && pred_hit_o == $past(pred_hit_o)));
endmodule

bind wakeup_pred wakeup_pred_chk #(.ADDR_W(ADDR_W), .INT_W(INT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .lkp_valid_i (lkp_valid_i),
  .lkp_pc_i    (lkp_pc_i),
  .upd_valid_i (upd_valid_i),
  .upd_pc_i    (upd_pc_i),
  .pred_valid_o(pred_valid_o),
  .pred_hit_o  (pred_hit_o),
  .pred_o      (pred_o)
);

// File: tb/wakeup_pred_bench.sv
`timescale 1ns/1ps
module wakeup_pred_bench;
  localparam int SETS = 8, WAYS = 4, ADDR_W = 16, INT_W = 8, CNT_W = 4, RLOG_W = 3;
  localparam int DEF_INIT = 2;

  logic              clk = 1'b0, rst_ni = 1'b0;
  logic              lkp_valid_i = 1'b0, upd_valid_i = 1'b0, r_neg_i = 1'b0;
  logic [ADDR_W-1:0] lkp_pc_i = '0, upd_pc_i = '0;
  logic [INT_W-1:0]  upd_wakeup_i = '0;
  logic [CNT_W-1:0]  upd_replays_i = '0;
  logic [RLOG_W-1:0] r_log_i = '0;
  logic              pred_valid_o, pred_hit_o;
  logic [INT_W-1:0]  pred_o;

  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  wakeup_pred #(
    .SETS(SETS), .WAYS(WAYS), .ADDR_W(ADDR_W), .INT_W(INT_W),
    .CNT_W(CNT_W), .RLOG_W(RLOG_W), .DEF_INIT(DEF_INIT)
  ) u_wakeup_pred (
    .clk_i(clk), .rst_ni(rst_ni),
    .lkp_valid_i(lkp_valid_i), .lkp_pc_i(lkp_pc_i),
    .upd_valid_i(upd_valid_i), .upd_pc_i(upd_pc_i),
    .upd_wakeup_i(upd_wakeup_i), .upd_replays_i(upd_replays_i),
    .r_neg_i(r_neg_i), .r_log_i(r_log_i),
    .pred_valid_o(pred_valid_o), .pred_hit_o(pred_hit_o), .pred_o(pred_o)
  );

  // requirement-level model
  int m_est [SETS][WAYS];
  int m_tag [SETS][WAYS];
  bit m_val [SETS][WAYS];
  int m_rr  [SETS];
  int m_def;

  bit    e_pend = 0, e_v, e_hit;
  int    e_pred;
  string e_tag;

  function automatic int step_f(int old, int w, int rep, bit neg, int lg);
    int pen = rep << (lg + 2);
    int s   = w * 16 + 8 + (neg ? -pen : pen);
    int n   = old + ((s - old) >>> 4);
    if (n < 0) n = 0;
    if (n > 4095) n = 4095;
    return n;
  endfunction

  function automatic int find_way(int pc);
    for (int w = 0; w < WAYS; w++)
      if (m_val[pc % SETS][w] && m_tag[pc % SETS][w] == pc / SETS) return w;
    return -1;
  endfunction

  task automatic model_update(int pc, int w, int rep, bit neg, int lg);
    int s = pc % SETS;
    int way = find_way(pc);
    if (way >= 0) m_est[s][way] = step_f(m_est[s][way], w, rep, neg, lg);
    else begin
      m_val[s][m_rr[s]] = 1;
      m_tag[s][m_rr[s]] = pc / SETS;
      m_est[s][m_rr[s]] = w * 16 + 8;
      m_rr[s] = (m_rr[s] + 1) % WAYS;
      m_def = step_f(m_def, w, rep, neg, lg);
    end
  endtask

  task automatic check_out(string tag, bit v, bit hit, int pred);
    checks++;
    if (pred_valid_o !== v || pred_hit_o !== hit || int'(pred_o) != pred) begin
      fails++;
      $display("FAIL %s: actual v=%0b hit=%0b pred=%0d expected v=%0b hit=%0b pred=%0d",
               tag, pred_valid_o, pred_hit_o, pred_o, v, hit, pred);
    end
  endtask

  task automatic cyc(bit lv, int lpc, bit uv, int upc, int w, int rep, bit neg, int lg,
                     string tag);
    int way;
    @(negedge clk);
    if (e_pend) check_out(e_tag, e_v, e_hit, e_pred);
    lkp_valid_i   = lv;
    lkp_pc_i      = ADDR_W'(lpc);
    upd_valid_i   = uv;
    upd_pc_i      = ADDR_W'(upc);
    upd_wakeup_i  = INT_W'(w);
    upd_replays_i = CNT_W'(rep);
    r_neg_i       = neg;
    r_log_i       = RLOG_W'(lg);
    if (uv) model_update(upc, w, rep, neg, lg);
    e_pend = 1;
    e_v    = lv;
    e_hit  = 0;
    e_pred = 0;
    e_tag  = tag;
    if (lv) begin
      way    = find_way(lpc);
      e_hit  = (way >= 0);
      e_pred = (way >= 0 ? m_est[lpc % SETS][way] : m_def) >> 4;
    end
  endtask

  task automatic look(int pc, string tag);
    cyc(1, pc, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic upd(int pc, int w, int rep, bit neg, int lg, string tag);
    cyc(0, 0, 1, pc, w, rep, neg, lg, tag);
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    for (int s = 0; s < SETS; s++) begin
      m_rr[s] = 0;
      for (int w = 0; w < WAYS; w++) begin m_val[s][w] = 0; m_est[s][w] = 0; m_tag[s][w] = 0; end
    end
    m_def = DEF_INIT * 16 + 8;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_out("R1 reset", 0, 0, 0);
    rst_ni = 1'b1;

    // R2: cold miss returns default
    look(16, "R2");
    look(17, "R2");
    // R3 / R7: allocation and default training
    upd(16, 9, 0, 0, 0, "R7");
    look(16, "R3");
    look(24, "R7");
    upd(40, 30, 3, 0, 2, "R7");
    look(41, "R7");
    // R4: hit update without replays
    for (int i = 0; i < 6; i++) upd(16, 3, 0, 0, 0, "R4");
    look(16, "R4");
    // R5: positive and negative penalty
    upd(16, 3, 2, 0, 3, "R5");
    look(16, "R5");
    upd(16, 20, 5, 1, 1, "R5");
    look(16, "R5");
    // R8: same-cycle update and lookup of a new address
    cyc(1, 77, 1, 77, 12, 0, 0, 0, "R8");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, "R1 idle");
    // R9: five tags into set 1, first is evicted
    for (int k = 0; k < 5; k++) upd(1 + 8 * k, 4 + k, 0, 0, 0, "R9");
    look(1, "R9 evicted");
    look(9, "R9 kept");
    look(33, "R9 newest");
    // R10: repeated lookup without update
    look(9, "R10");
    look(9, "R10");
    // R6: saturate high then low
    for (int i = 0; i < 200; i++) upd(5, 255, 15, 0, 7, "R6");
    look(5, "R6 high");
    for (int i = 0; i < 200; i++) upd(5, 0, 15, 1, 7, "R6");
    look(5, "R6 low");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      bit lv  = 1'($urandom_range(0, 1));
      bit uv  = 1'($urandom_range(0, 1));
      int lpc = $urandom_range(0, 63);
      int upc = ($urandom_range(0, 3) == 0) ? lpc : $urandom_range(0, 63);
      int rep = ($urandom_range(0, 1) == 0) ? 0 : $urandom_range(0, 15);
      cyc(lv, lpc, uv, upc, $urandom_range(0, 255), rep, 1'($urandom_range(0, 1)),
          $urandom_range(0, 7), "R4 R5 R9 random");
    end
    cyc(0, 0, 0, 0, 0, 0, 0, 0, "R1 idle");
    @(negedge clk);
    check_out(e_tag, e_v, e_hit, e_pred);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule